// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block produces memory addresses for indirect operand fetches. It keeps four index pointers. Each pointer has its own length and base register. Four modify registers are shared by all pointers. On an access the caller names one pointer and one modify register. The current value of the pointer goes out as the address, and the pointer then advances by the chosen signed modify value.

When a pointer's length register is zero, the pointer moves linearly and wraps only at the edge of the address space. When the length is nonzero, the pointer stays inside a ring that runs from its base to base+length-1. A step past either end folds back into the ring. Software loads the registers through a single write port. Loading an index also sets that pointer's base, so a ring can be set up with one write to the index and one write to the length.

The address is registered and appears one cycle after the access request. The memory itself, bit-reversed addressing and the instruction decode that drives the selects belong to other blocks.

Top module: `ring_agu`

## Requirements
- R1: After reset, every pointer, modify, length and base register holds zero, `addr_vld` is low and `addr_o` is zero.
- R2: A request with `acc_en` high raises `addr_vld` on the next cycle, with `addr_o` equal to the selected pointer's value before that request. With `acc_en` low, `addr_vld` is low on the next cycle.
- R3: After a request, the selected pointer has advanced by the selected modify register. The modify value is read as a 14-bit two's-complement number, and the new value is seen by the next request to that pointer.
- R4: With a length of zero the step is linear modulo 2^14. Stepping up from 0x3FFF reaches 0x0002 with a modify of 3, and stepping down from 0x0000 reaches 0x3FFF with a modify of -1.
- R5: With a nonzero length L, a pointer inside its ring that steps by a modify of magnitude at most L stays inside [base, base+L-1]. A step past the top end has L subtracted.
- R6: In a ring, a negative step below the base has L added. For example, base 0x50, L=4 and modify -3 visit 0x50, 0x51, 0x52, 0x53.
- R7: The write port encodes `wr_kind` as 0 for index, 1 for modify, 2 for length and 3 for base, and `wr_idx` picks the register. An index write loads both the pointer and its base. A base write loads only the base.
- R8: When the index of the pointer being accessed is written in the same cycle, the written value replaces the post-modified value. The address output of that request still shows the old pointer.
- R9: A request uses the register values held before the clock edge, even if one of them is written in the same cycle. Pointers that are neither selected nor written keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register class: 0 index, 1 modify, 2 length, 3 base |
| wr_idx | input | 2 | Register number within the class |
| wr_data | input | 14 | Write value |
| acc_en | input | 1 | Access request |
| acc_ptr | input | 2 | Pointer to use |
| acc_mod | input | 2 | Modify register to apply |
| addr_vld | output | 1 | Address output valid, one cycle after a request |
| addr_o | output | 14 | Issued address |

## Verification
The bench looks at the point where the ring wraps in both directions. A design with an off-by-one bound would return base+L, or fail to fold back a step that lands exactly one place below the base. Linear pointers are driven across 0x3FFF and 0x0000. A design that applied ring logic at length zero, or that lost the modify sign, would jump to the wrong address there. Same-cycle collisions are covered next: index write against access, and modify write against access. A wrong priority would show up as a post-modified value where the written one belongs, or as the new modify value being applied early. A base write that moves the ring under a live pointer is also checked, because a base that was never latched separately would wrap to the wrong place.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    WK_INDEX  = 2'd0,
    WK_MODIFY = 2'd1,
    WK_LENGTH = 2'd2,
    WK_BASE   = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/agu_cfg_bank.sv
module agu_cfg_bank #(
  parameter int AW = 14,
  parameter int N  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         we_vec,
  input  logic [AW-1:0]        wdata,
  output logic [N-1:0][AW-1:0] val_q
);
  for (genvar k = 0; k < N; k++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)         val_q[k] <= '0;
      else if (we_vec[k]) val_q[k] <= wdata;
    end
  end
endmodule

// File: rtl/agu_wrap_step.sv
module agu_wrap_step #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] modv,
  input  logic [AW-1:0] basev,
  input  logic [AW-1:0] lenv,
  output logic [AW-1:0] nxt
);
  localparam int EW = AW + 2;

  // Offset inside the ring plus signed step, folded back by one length.
  function automatic logic [AW-1:0] ring_step(
    input logic [AW-1:0] c, input logic [AW-1:0] m,
    input logic [AW-1:0] b, input logic [AW-1:0] l);
    logic [AW-1:0]        off;
    logic signed [EW-1:0] s;
    logic signed [EW-1:0] ls;
    if (l == '0) return c + m;
    off = c - b;
    s   = $signed({2'b00, off}) + $signed({{2{m[AW-1]}}, m});
    ls  = $signed({2'b00, l});
    if (s >= ls)      s = s - ls;
    else if (s < 0)   s = s + ls;
    return b + s[AW-1:0];
  endfunction

  assign nxt = ring_step(cur, modv, basev, lenv);
endmodule

// File: rtl/agu_ptr_bank.sv
module agu_ptr_bank #(
  parameter int AW = 14,
  parameter int N  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         wr_vec,
  input  logic [AW-1:0]        wdata,
  input  logic [N-1:0]         upd_vec,
  input  logic [AW-1:0]        upd_val,
  output logic [N-1:0][AW-1:0] ptr_q
);
  for (genvar k = 0; k < N; k++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n)          ptr_q[k] <= '0;
      else if (wr_vec[k])  ptr_q[k] <= wdata;
      else if (upd_vec[k]) ptr_q[k] <= upd_val;
    end
  end
endmodule

// File: rtl/ring_agu.sv
module ring_agu #(
  parameter int AW   = 14,
  parameter int NPTR = 4,
  parameter int NMOD = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_kind,
  input  logic [1:0]  wr_idx,
  input  logic [13:0] wr_data,
  input  logic        acc_en,
  input  logic [1:0]  acc_ptr,
  input  logic [1:0]  acc_mod,
  output logic        addr_vld,
  output logic [13:0] addr_o
);
  import agu_pkg::*;

  localparam int PW = (NPTR > 1) ? $clog2(NPTR) : 1;
  localparam int MW = (NMOD > 1) ? $clog2(NMOD) : 1;

  logic [NPTR-1:0][AW-1:0] ptr_q, base_q, len_q;
  logic [NMOD-1:0][AW-1:0] mod_q;
  logic [NPTR-1:0]         idx_we_vec, base_we_vec, len_we_vec, upd_vec;
  logic [NMOD-1:0]         mod_we_vec;
  logic [AW-1:0]           sel_cur, sel_mod, sel_base, sel_len, sel_nxt;
  logic [PW-1:0]           ap;
  logic [MW-1:0]           am;
  logic [PW-1:0]           wi_p;
  logic [MW-1:0]           wi_m;

  assign ap   = PW'(acc_ptr);
  assign am   = MW'(acc_mod);
  assign wi_p = PW'(wr_idx);
  assign wi_m = MW'(wr_idx);

  always_comb begin
    idx_we_vec  = '0;
    base_we_vec = '0;
    len_we_vec  = '0;
    mod_we_vec  = '0;
    upd_vec     = '0;
    if (wr_en) begin
      unique case (wr_kind_e'(wr_kind))
        WK_INDEX:  begin idx_we_vec[wi_p] = 1'b1; base_we_vec[wi_p] = 1'b1; end
        WK_MODIFY: mod_we_vec[wi_m] = 1'b1;
        WK_LENGTH: len_we_vec[wi_p] = 1'b1;
        WK_BASE:   base_we_vec[wi_p] = 1'b1;
        default:   ;
      endcase
    end
    if (acc_en) upd_vec[ap] = 1'b1;
  end

  assign sel_cur  = ptr_q[ap];
  assign sel_base = base_q[ap];
  assign sel_len  = len_q[ap];
  assign sel_mod  = mod_q[am];

  agu_cfg_bank #(.AW(AW), .N(NMOD)) u_mod (
    .clk(clk), .rst_n(rst_n), .we_vec(mod_we_vec), .wdata(wr_data[AW-1:0]), .val_q(mod_q));
  agu_cfg_bank #(.AW(AW), .N(NPTR)) u_len (
    .clk(clk), .rst_n(rst_n), .we_vec(len_we_vec), .wdata(wr_data[AW-1:0]), .val_q(len_q));
  agu_cfg_bank #(.AW(AW), .N(NPTR)) u_base (
    .clk(clk), .rst_n(rst_n), .we_vec(base_we_vec), .wdata(wr_data[AW-1:0]), .val_q(base_q));

  agu_wrap_step #(.AW(AW)) u_step (
    .cur(sel_cur), .modv(sel_mod), .basev(sel_base), .lenv(sel_len), .nxt(sel_nxt));

  agu_ptr_bank #(.AW(AW), .N(NPTR)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_vec(idx_we_vec), .wdata(wr_data[AW-1:0]),
    .upd_vec(upd_vec), .upd_val(sel_nxt), .ptr_q(ptr_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_vld <= 1'b0;
      addr_o   <= '0;
    end else begin
      addr_vld <= acc_en;
      if (acc_en) addr_o <= 14'(sel_cur);
    end
  end
endmodule

// File: rtl/ring_agu_chk.sv
module ring_agu_chk #(
  parameter int AW   = 14,
  parameter int NPTR = 4,
  parameter int NMOD = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [1:0]              wr_kind,
  input logic [1:0]              wr_idx,
  input logic [13:0]             wr_data,
  input logic                    acc_en,
  input logic [1:0]              acc_ptr,
  input logic [1:0]              acc_mod,
  input logic                    addr_vld,
  input logic [13:0]             addr_o,
  input logic [NPTR-1:0][AW-1:0] ptr_q,
  input logic [NPTR-1:0][AW-1:0] base_q,
  input logic [NPTR-1:0][AW-1:0] len_q,
  input logic [NMOD-1:0][AW-1:0] mod_q
);
  logic [AW-1:0] c_cur, c_base, c_len, c_mod, c_off, c_mag;
  logic          c_touch, c_fits;

  assign c_cur   = ptr_q[acc_ptr];
  assign c_base  = base_q[acc_ptr];
  assign c_len   = len_q[acc_ptr];
  assign c_mod   = mod_q[acc_mod];
  assign c_off   = c_cur - c_base;
  assign c_mag   = c_mod[AW-1] ? (~c_mod + 1'b1) : c_mod;
  assign c_touch = wr_en && (wr_kind != 2'd1) && (wr_idx == acc_ptr);
  assign c_fits  = (c_len != '0) && (c_off < c_len) && (c_mag <= c_len);

  a_r2_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> addr_vld);
  a_r2_valid_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !addr_vld);
  a_r2_addr_old: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> addr_o == 14'($past(c_cur)));
  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && c_len == '0 && !c_touch) |=>
      ptr_q[$past(acc_ptr)] == $past(c_cur + c_mod));
  a_r5_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && c_fits && !c_touch) |=>
      (ptr_q[$past(acc_ptr)] - base_q[$past(acc_ptr)]) < len_q[$past(acc_ptr)]);
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == 2'd0) |=>
      ptr_q[$past(wr_idx)] == $past(wr_data[AW-1:0]) &&
      base_q[$past(wr_idx)] == $past(wr_data[AW-1:0]));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !wr_en) |=> $stable(ptr_q) && !addr_vld);
endmodule

bind ring_agu ring_agu_chk #(.AW(AW), .NPTR(NPTR), .NMOD(NMOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
  .wr_data(wr_data), .acc_en(acc_en), .acc_ptr(acc_ptr), .acc_mod(acc_mod),
  .addr_vld(addr_vld), .addr_o(addr_o), .ptr_q(ptr_q), .base_q(base_q),
  .len_q(len_q), .mod_q(mod_q));

// File: tb/ring_agu_tb_top.sv
module ring_agu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = '0;
  logic [1:0]  wr_idx = '0;
  logic [13:0] wr_data = '0;
  logic        acc_en = 1'b0;
  logic [1:0]  acc_ptr = '0;
  logic [1:0]  acc_mod = '0;
  logic        addr_vld;
  logic [13:0] addr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int m_ptr[4], m_base[4], m_len[4], m_mod[4];
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  ring_agu dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .acc_en(acc_en), .acc_ptr(acc_ptr), .acc_mod(acc_mod),
    .addr_vld(addr_vld), .addr_o(addr_o));

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int model_next(int p, int m);
    int sm, off, r;
    sm = (m_mod[m] >= 8192) ? m_mod[m] - 16384 : m_mod[m];
    if (m_len[p] == 0) return (m_ptr[p] + sm) & 16'h3FFF;
    off = (m_ptr[p] - m_base[p]) & 16'h3FFF;
    r = ((off + sm) % m_len[p] + m_len[p]) % m_len[p];
    return (m_base[p] + r) & 16'h3FFF;
  endfunction

  // One cycle of stimulus; model applies access update first, then write.
  task automatic cyc(bit we, int wk, int wi, int wd, bit ae, int ap, int am, string tag);
    @(negedge clk);
    wr_en = we; wr_kind = 2'(wk); wr_idx = 2'(wi); wr_data = 14'(wd);
    acc_en = ae; acc_ptr = 2'(ap); acc_mod = 2'(am);
    if (ae) begin
      exp_q.push_back(m_ptr[ap]);
      tag_q.push_back(tag);
      m_ptr[ap] = model_next(ap, am);
    end
    if (we) begin
      case (wk)
        0: begin m_ptr[wi] = wd & 16'h3FFF; m_base[wi] = wd & 16'h3FFF; end
        1: m_mod[wi]  = wd & 16'h3FFF;
        2: m_len[wi]  = wd & 16'h3FFF;
        default: m_base[wi] = wd & 16'h3FFF;
      endcase
    end
  endtask

  task automatic wr(int wk, int wi, int wd);
    cyc(1'b1, wk, wi, wd, 1'b0, 0, 0, "");
  endtask
  task automatic acc(int ap, int am, string tag);
    cyc(1'b0, 0, 0, 0, 1'b1, ap, am, tag);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 0, 1'b0, 0, 0, "");
  endtask

  // Monitor: pops expected addresses as the design presents them.
  always @(negedge clk) begin
    if (rst_n && addr_vld) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2: actual unexpected valid 0x%0h expected no valid", addr_o);
      end else begin
        check(tag_q.pop_front(), int'(addr_o), exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      m_ptr[k] = 0; m_base[k] = 0; m_len[k] = 0; m_mod[k] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1 vld", int'(addr_vld), 0);
    check("R1 addr", int'(addr_o), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) acc(k, k, "R1 ptr zero");
    idle(2);

    wr(1, 0, 1); wr(1, 1, 16'h3FFF); wr(1, 2, 3); wr(1, 3, 16'h3FFD);
    // R3 linear post-modify, back to back
    wr(0, 0, 100);
    acc(0, 0, "R3"); acc(0, 0, "R3"); acc(0, 0, "R3"); acc(0, 1, "R3 neg");
    idle(1);
    // R4 top and bottom of the address space with length zero
    wr(0, 1, 16'h3FFF);
    acc(1, 2, "R4 up"); acc(1, 2, "R4 up");
    wr(0, 1, 1);
    acc(1, 1, "R4 down"); acc(1, 1, "R4 down"); acc(1, 1, "R4 down");
    // R5 upward ring: base 0x200, L=5, step 3
    wr(0, 2, 16'h200); wr(2, 2, 5);
    for (int i = 0; i < 7; i++) acc(2, 2, "R5 ring up");
    // R5 step equal to length
    wr(2, 2, 3);
    acc(2, 2, "R5 full step"); acc(2, 2, "R5 full step");
    // R6 downward ring: base 0x50, L=4, step -3
    wr(0, 3, 16'h50); wr(2, 3, 4);
    for (int i = 0; i < 6; i++) acc(3, 3, "R6 ring down");
    acc(3, 1, "R6 step -1"); acc(3, 1, "R6 step -1");
    // R7 base write moves ring under a live pointer
    wr(0, 0, 16'h10); wr(2, 0, 8); wr(3, 0, 16'h0C);
    for (int i = 0; i < 6; i++) acc(0, 0, "R7 base");
    // R8 index write collides with access
    cyc(1'b1, 0, 0, 16'h300, 1'b1, 0, 0, "R8 old addr");
    acc(0, 0, "R8 write wins"); acc(0, 0, "R8");
    // R9 modify write in same cycle as its use: old value applies
    wr(2, 1, 0);
    wr(0, 1, 16'h40);
    cyc(1'b1, 1, 1, 7, 1'b1, 1, 1, "R9 old mod");
    acc(1, 1, "R9 old mod"); acc(1, 1, "R9 new mod");
    // R9 length write on pointer in use: old length applies
    wr(0, 2, 16'h100); wr(2, 2, 2); wr(1, 2, 1);
    acc(2, 2, "R9 old len");
    cyc(1'b1, 2, 2, 0, 1'b1, 2, 2, "R9 old len");
    acc(2, 2, "R9 new len"); acc(2, 2, "R9 new len");
    // R9 untouched pointers kept their values
    for (int k = 0; k < 4; k++) acc(k, 0, "R9 hold");
    idle(3);
    check("R2 drained", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule